// File: doc/BRIEF.md
# Switchable Cartridge Memory-Map Decoder

This block sits on a game cartridge between the console bus and the memory devices. It takes seven bus-derived decode inputs, taken together as a 7-bit code, and produces five active-low chip selects. Three of them serve the program ROM: a full-range select and two half-range selects. One is an auxiliary select. The last is the save-RAM select.

A mode input sets how the CPU address reaches the ROM address pins. In the high-bank layout the address passes straight through. In the low-bank layout each 64 KB CPU bank supplies only a 32 KB window. The bank bits therefore move down one place, and CPU bit 15 is discarded.

The save-RAM select is held off while reset is active and while the main supply is reported as failing. This stops stray writes during power-up and power-down. The block holds no state: every output follows its inputs combinationally.

Top module: `cart_map_decoder`

## Requirements
- R1: Every select output is active low and sits high when none of its product terms holds. With dec_in = 0, rst_n = 1 and pwr_good = 1, all five selects read 1.
- R2: The decode code dec_in maps bit 0 to A, bit 1 to B, bit 2 to C, bit 3 to D, bit 4 to E, bit 5 to F and bit 6 to G. rom_cs_n is low exactly when (G&~C&A) | (B&~C&A).
- R3: rom_hi_cs_n is low exactly when (E&G&~C&A) | (E&B&~C&A).
- R4: rom_lo_cs_n is low exactly when (~E&G&~C&A) | (~E&B&~C&A).
- R5: aux_cs_n is low when (A&B&C&~D&E&F&G) | (A&~B&~C&D&E&F&~G), and also whenever pwr_good is 0.
- R6: With rst_n = 1 and pwr_good = 1, ram_cs_n is low exactly when (A&B&C&~D&~E&F&G) | (A&~B&~C&D&E&~F&~G).
- R7: While rst_n is 0, ram_cs_n is 1 for every decode code.
- R8: While pwr_good is 0, ram_cs_n is 1 for every decode code.
- R9: With map_mode = 0 (low-bank layout), rom_addr[14:0] equals cpu_addr[14:0] and rom_addr[k] equals cpu_addr[k+1] for every k from 15 up to ROM_AW-1.
- R10: With map_mode = 1 (high-bank layout), rom_addr equals cpu_addr[ROM_AW-1:0].
- R11: The block holds no state. A change on map_mode or on any other input shows on the outputs without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | System reset, active low; blocks the save-RAM select |
| pwr_good | input | 1 | Main supply is above the backup threshold when 1 |
| map_mode | input | 1 | 0 selects the low-bank 32 KB-window layout, 1 selects the high-bank linear layout |
| dec_in | input | 7 | Decode code: bit 0 is A, up to bit 6, which is G |
| cpu_addr | input | ROM_AW+1 | CPU address bits used for ROM addressing |
| rom_addr | output | ROM_AW | Remapped ROM address |
| rom_cs_n | output | 1 | Full-range ROM select, active low |
| rom_hi_cs_n | output | 1 | ROM select for the E=1 half, active low |
| rom_lo_cs_n | output | 1 | ROM select for the E=0 half, active low |
| aux_cs_n | output | 1 | Auxiliary select, forced low on supply failure |
| ram_cs_n | output | 1 | Save-RAM select, active low, gated by reset and supply |

## Verification
The bench steps through all 128 decode codes in each of the eight combinations of map_mode, rst_n and pwr_good. This sweep separates each single-term and two-term equation from its near neighbours. It also shows whether the reset and supply gates act on the save-RAM select alone, while the other selects ignore rst_n. Each code is paired with a pseudo-random CPU address. This exposes a wrong shift or a missing window bit in both layouts. A final step flips map_mode with no clock edge, to show that the address remap follows combinationally.

// File: rtl/cart_map_pkg.sv
// Package: types shared by the cartridge map decoder.
// Assumes the decode code is packed with G as the most significant bit.
package cart_map_pkg;

    // Address layout selection.
    typedef enum logic {
        MAP_LOW  = 1'b0,
        MAP_HIGH = 1'b1
    } map_mode_e;

    // Decode code, G down to A.
    typedef struct packed {
        logic g;
        logic f;
        logic e;
        logic d;
        logic c;
        logic b;
        logic a;
    } dec_bits_t;

    // Raw product-term results, active high, before any gating.
    typedef struct packed {
        logic rom_all;
        logic rom_hi;
        logic rom_lo;
        logic aux;
        logic ram;
    } sel_terms_t;

    localparam int WINDOW_BITS = 15;

endpackage

// File: rtl/cart_sel_terms.sv
// Module: evaluates the fixed sum-of-products select equations.
// Assumes nothing beyond a stable decode code; purely combinational.
module cart_sel_terms
    import cart_map_pkg::*;
(
    input  dec_bits_t  dec,
    output sel_terms_t terms
);

    // Shared factor: A true, C false, and either G or B true.
    logic rom_base;

    // Purpose: form every product term from the decode bits.
    always_comb begin
        rom_base      = dec.a & ~dec.c & (dec.g | dec.b);
        terms.rom_all = rom_base;
        terms.rom_hi  = rom_base & dec.e;
        terms.rom_lo  = rom_base & ~dec.e;
        terms.aux     = (dec.g & dec.f & dec.e & ~dec.d & dec.c & dec.b & dec.a)
                      | (~dec.g & dec.f & dec.e & dec.d & ~dec.c & ~dec.b & dec.a);
        terms.ram     = (dec.g & dec.f & ~dec.e & ~dec.d & dec.c & dec.b & dec.a)
                      | (~dec.g & ~dec.f & dec.e & dec.d & ~dec.c & ~dec.b & dec.a);
    end

endmodule

// File: rtl/cart_addr_remap.sv
// Module: maps the CPU address onto ROM address pins per layout mode.
// Assumes the CPU address is one bit wider than the ROM address.
module cart_addr_remap
    import cart_map_pkg::*;
#(
    parameter int ROM_AW = 22
) (
    input  map_mode_e         mode,
    input  logic [ROM_AW:0]   cpu_addr,
    output logic [ROM_AW-1:0] rom_addr
);

    localparam int WIN = WINDOW_BITS;

    // Per-bit mux: window bits pass, bank bits pick shifted or straight.
    for (genvar i = 0; i < ROM_AW; i++) begin : g_bit
        if (i < WIN) begin : g_win
            assign rom_addr[i] = cpu_addr[i];
        end else begin : g_bank
            assign rom_addr[i] = (mode == MAP_LOW) ? cpu_addr[i+1] : cpu_addr[i];
        end
    end

endmodule

// File: rtl/cart_sel_drive.sv
// Module: converts raw terms into active-low pins and applies the
// reset and supply gating. Assumes rst_n and pwr_good are already clean levels.
module cart_sel_drive
    import cart_map_pkg::*;
(
    input  sel_terms_t terms,
    input  logic       rst_n,
    input  logic       pwr_good,
    output logic       rom_cs_n,
    output logic       rom_hi_cs_n,
    output logic       rom_lo_cs_n,
    output logic       aux_cs_n,
    output logic       ram_cs_n
);

    // Purpose: invert to active low; gate the save RAM, force aux on supply loss.
    always_comb begin
        rom_cs_n    = ~terms.rom_all;
        rom_hi_cs_n = ~terms.rom_hi;
        rom_lo_cs_n = ~terms.rom_lo;
        aux_cs_n    = ~(terms.aux | ~pwr_good);
        ram_cs_n    = ~(terms.ram & rst_n & pwr_good);
    end

endmodule

// File: rtl/cart_map_decoder.sv
// Module: top of the switchable cartridge memory-map decoder.
// Assumes static-level inputs; holds no registered state.
module cart_map_decoder
    import cart_map_pkg::*;
#(
    parameter int ROM_AW = 22
) (
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              map_mode,
    input  logic [6:0]        dec_in,
    input  logic [ROM_AW:0]   cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_cs_n,
    output logic              rom_hi_cs_n,
    output logic              rom_lo_cs_n,
    output logic              aux_cs_n,
    output logic              ram_cs_n
);

    dec_bits_t  dec;
    sel_terms_t terms;
    map_mode_e  mode;

    assign dec  = dec_bits_t'(dec_in);
    assign mode = map_mode_e'(map_mode);

    cart_sel_terms u_terms (
        .dec   (dec),
        .terms (terms)
    );

    cart_sel_drive u_drive (
        .terms       (terms),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .rom_cs_n    (rom_cs_n),
        .rom_hi_cs_n (rom_hi_cs_n),
        .rom_lo_cs_n (rom_lo_cs_n),
        .aux_cs_n    (aux_cs_n),
        .ram_cs_n    (ram_cs_n)
    );

    cart_addr_remap #(.ROM_AW(ROM_AW)) u_remap (
        .mode     (mode),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr)
    );

    // Purpose: guard pin-level relations across the sub-blocks.
    always_comb begin
        // R7
        ram_rst_block_chk: assert (rst_n || ram_cs_n)
            else $error("save RAM selected during reset");
        // R8
        ram_pwr_block_chk: assert (pwr_good || ram_cs_n)
            else $error("save RAM selected on failing supply");
        // R5
        aux_pwr_force_chk: assert (pwr_good || !aux_cs_n)
            else $error("aux select not forced on supply loss");
        // R3
        rom_half_excl_chk: assert (rom_hi_cs_n || rom_lo_cs_n)
            else $error("both ROM halves selected");
        // R4
        rom_half_cover_chk: assert ((rom_hi_cs_n && rom_lo_cs_n) || !rom_cs_n)
            else $error("ROM half selected without full-range select");
        // R9
        addr_window_chk: assert (rom_addr[WINDOW_BITS-1:0] == cpu_addr[WINDOW_BITS-1:0])
            else $error("window bits not passed through");
    end

endmodule

// File: tb/cart_map_decoder_test.sv
// Bench: exhaustive sweep against a behavioural model, checked every clock.
module cart_map_decoder_test;

    localparam int ROM_AW = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pwr_good = 1'b1;
    logic              map_mode = 1'b0;
    logic [6:0]        dec_in = '0;
    logic [ROM_AW:0]   cpu_addr = '0;
    logic [ROM_AW-1:0] rom_addr;
    logic rom_cs_n, rom_hi_cs_n, rom_lo_cs_n, aux_cs_n, ram_cs_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    cart_map_decoder #(.ROM_AW(ROM_AW)) uut (
        .rst_n(rst_n), .pwr_good(pwr_good), .map_mode(map_mode),
        .dec_in(dec_in), .cpu_addr(cpu_addr), .rom_addr(rom_addr),
        .rom_cs_n(rom_cs_n), .rom_hi_cs_n(rom_hi_cs_n), .rom_lo_cs_n(rom_lo_cs_n),
        .aux_cs_n(aux_cs_n), .ram_cs_n(ram_cs_n)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s code=%0d mode=%0d rst_n=%0d pg=%0d act=%0h exp=%0h",
                     req, dec_in, map_mode, rst_n, pwr_good, act, exp);
        end
    endtask

    // Behavioural model of the requirements, returning the active-low pin level.
    function automatic bit bitof(input int code, input int idx);
        return ((code >> idx) & 1) != 0;
    endfunction

    task automatic check_all();
        int c;
        bit a, b, cc, d, e, f, g;
        longint addr, exp_addr;
        c = int'(dec_in);
        a = bitof(c,0); b = bitof(c,1); cc = bitof(c,2); d = bitof(c,3);
        e = bitof(c,4); f = bitof(c,5); g = bitof(c,6);
        chk("R2 rom_cs_n", rom_cs_n, !((g && !cc && a) || (b && !cc && a)));
        chk("R3 rom_hi_cs_n", rom_hi_cs_n, !(e && ((g && !cc && a) || (b && !cc && a))));
        chk("R4 rom_lo_cs_n", rom_lo_cs_n, !(!e && ((g && !cc && a) || (b && !cc && a))));
        chk("R5 aux_cs_n", aux_cs_n,
            !((a && b && cc && !d && e && f && g) || (a && !b && !cc && d && e && f && !g) || !pwr_good));
        if (!rst_n)
            chk("R7 ram_cs_n", ram_cs_n, 1);
        else if (!pwr_good)
            chk("R8 ram_cs_n", ram_cs_n, 1);
        else
            chk("R6 ram_cs_n", ram_cs_n,
                !((a && b && cc && !d && !e && f && g) || (a && !b && !cc && d && e && !f && !g)));
        addr = longint'(cpu_addr);
        if (map_mode == 1'b0) begin
            exp_addr = (((addr >> 16) << 15) | (addr % 32768)) % (longint'(1) << ROM_AW);
            chk("R9 rom_addr", rom_addr, exp_addr);
        end else begin
            exp_addr = addr % (longint'(1) << ROM_AW);
            chk("R10 rom_addr", rom_addr, exp_addr);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        seed = 32'h1234_5678;
        // Reset state: save RAM held off.
        @(negedge clk);
        chk("R7 reset state ram_cs_n", ram_cs_n, 1);
        // Idle code: all selects high.
        @(posedge clk); #2; rst_n = 1'b1; pwr_good = 1'b1; dec_in = '0;
        @(negedge clk);
        chk("R1 idle rom_cs_n", rom_cs_n, 1);
        chk("R1 idle rom_hi_cs_n", rom_hi_cs_n, 1);
        chk("R1 idle rom_lo_cs_n", rom_lo_cs_n, 1);
        chk("R1 idle aux_cs_n", aux_cs_n, 1);
        chk("R1 idle ram_cs_n", ram_cs_n, 1);
        // Exhaustive sweep.
        for (int m = 0; m < 2; m++) begin
            for (int r = 0; r < 2; r++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int code = 0; code < 128; code++) begin
                        @(posedge clk); #2;
                        seed = seed * 32'd1103515245 + 32'd12345;
                        map_mode = m[0]; rst_n = r[0]; pwr_good = p[0];
                        dec_in = code[6:0];
                        cpu_addr = (ROM_AW+1)'({seed, seed[15:0]} >> 5);
                        @(negedge clk);
                        check_all();
                    end
                end
            end
        end
        // R11: mode flip shows with no clock edge.
        @(posedge clk); #2;
        rst_n = 1'b1; pwr_good = 1'b1; map_mode = 1'b1;
        cpu_addr = (ROM_AW+1)'(23'h4A_5A5A);
        #1;
        chk("R11 high layout", rom_addr, 22'h0A_5A5A);
        map_mode = 1'b0;
        #1;
        chk("R11 low layout after flip", rom_addr, 22'h25_5A5A);
        dec_in = 7'b1010011;
        #1;
        chk("R11 rom_cs_n follows code", rom_cs_n, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule